// File: doc/BRIEF.md
# Byte-Stream Network Mailbox

This block is a small register-mapped peripheral. A processor uses it to exchange network frames with a byte-stream link, one byte per register access. On the receive side, frames arrive on a valid/ready byte stream that has an end-of-frame marker. The block stores each frame in a local buffer. It then presents the frame length in a count register and the data in a single-byte read port. That count steps down by one on each data read.

On the transmit side, software first writes the number of bytes it intends to send. It then writes that many bytes, one access each, to a single-byte write port. Once the final byte is in, the block streams the frame out on a valid/ready byte stream and marks the final byte.

An interrupt register gathers three sources into one interrupt output:
- transmit done, cleared by writing 1;
- receive data available, cleared by writing 1;
- a software test bit, with its own set and clear rules.

While the receive-available flag is pending, the block refuses new frames. The buffer depth is the `DEPTH` parameter. It may be raised up to 65536 bytes per frame, and it must be at least 2.

Top module: `nmb_mailbox`

## Requirements
- R1: The word at offset 0x00 reads 0x45545942 and the word at 0x04 reads 0x3158424D. Together they form an eight-character ASCII identifier, with the first character in the least significant byte of 0x00 and the version digit '1' in the top byte of 0x04. Offset 0x18 reads the `INFO_WORD` parameter. Any offset not listed in this brief reads 0, and so does the write-only data port at 0x20. Writes to 0x00, 0x04, 0x08, 0x0C, 0x18 and to unlisted offsets change nothing.
- R2: Bit 0 of offset 0x08 reads 1 in two cases: while a receive frame has been partly taken in without its last byte, and from the moment a transmit count is accepted until the last output byte is handed off. Otherwise it reads 0.
- R3: When the last byte of a receive frame is accepted, offset 0x0C takes the frame length and bit 1 of the interrupt register (offset 0x14) becomes 1.
- R4: Each read of offset 0x1C returns the next stored receive byte in bits 7:0, with bits 31:8 reading 0, and lowers the count at 0x0C by one. With the count at 0, the read returns 0 and the count stays 0.
- R5: A receive frame longer than `DEPTH` bytes is truncated. Its first `DEPTH` bytes are kept, and the count is loaded with `DEPTH`.
- R6: The receive ready output is low whenever interrupt bit 1 is 1 or the receive count is nonzero. No frame is taken in during that time.
- R7: Writing N to offset 0x10 arms a transmit of N bytes, with N clamped to `DEPTH`. Offset 0x10 reads back N until the Nth byte has been written to offset 0x20, and then reads 0. Only bits 7:0 of each 0x20 write are used. The bytes then leave on the transmit stream in write order. Last is high only on the final byte, and data and last stay stable while valid waits for ready.
- R8: Bit 0 of offset 0x14 becomes 1 when the final transmit byte is handed off. Writing 1 to bit 0 or bit 1 of offset 0x14 clears that bit, and writing 0 to either leaves it unchanged.
- R9: Bit 31 of offset 0x14 takes the value of bit 31 of each write to that offset. A read of 0x14 returns its current value and then clears it.
- R10: The interrupt output is 1 exactly when bit 0, bit 1 or bit 31 of offset 0x14 is 1.
- R11: A write to offset 0x10 is ignored while a transmit is being collected or sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Receive byte ends the frame |
| rx_ready | output | 1 | Block can take a receive byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Transmit byte ends the frame |
| tx_ready | input | 1 | Sink takes the transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The receive and transmit pointers and counts show up at the ports as soon as data moves. A count that is off shows in the very next read of 0x0C or 0x10, or as a byte out of order on a 0x1C read. A read pointer that is off shows as a wrong byte on a 0x1C read. On transmit, a length that is off moves the last marker one byte early or late, and the transmit-done flag shows in the next read of 0x14. A wrong interrupt flag appears at once on the interrupt pin. If the receive-pending flag is wrong, it appears at once as receive ready being high while a frame is still unread.

// File: rtl/nmb_pkg.sv
// Package: register offsets, identifier and interrupt bit positions shared
// by the mailbox and its checker. Assumes a 6-bit byte offset.
package nmb_pkg;
    localparam logic [5:0] OFS_ID_LO = 6'h00;
    localparam logic [5:0] OFS_ID_HI = 6'h04;
    localparam logic [5:0] OFS_BUSY  = 6'h08;
    localparam logic [5:0] OFS_RXCNT = 6'h0C;
    localparam logic [5:0] OFS_TXCNT = 6'h10;
    localparam logic [5:0] OFS_IRQ   = 6'h14;
    localparam logic [5:0] OFS_INFO  = 6'h18;
    localparam logic [5:0] OFS_RXDAT = 6'h1C;
    localparam logic [5:0] OFS_TXDAT = 6'h20;

    // "BYTEMBX1", first character in the least significant byte
    localparam logic [63:0] DEV_ID = 64'h3158424D_45545942;

    localparam int IRQ_TX   = 0;
    localparam int IRQ_RX   = 1;
    localparam int IRQ_TEST = 31;
endpackage

// File: rtl/nmb_rx_path.sv
// Receive path: takes one frame from a valid/ready byte stream into a local
// buffer, then hands bytes out one per pop while counting down.
// Assumes DEPTH >= 2; bytes beyond DEPTH in a frame are dropped.
module nmb_rx_path #(
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    output logic          rx_ready,
    input  logic          blocked,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic [7:0]    head_byte,
    output logic          frame_done,
    output logic          receiving
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] wr_cnt;
    logic [CW-1:0] rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign rx_ready   = !blocked && (cnt_q == '0);
    assign accept     = rx_valid && rx_ready;
    assign frame_done = accept && rx_last;
    assign receiving  = (wr_cnt != '0);
    assign count      = cnt_q;
    assign head_byte  = (cnt_q != '0) ? mem[rd_ptr[AW-1:0]] : 8'h00;

    // Store accepted bytes while room remains
    always_ff @(posedge clk) begin
        if (accept && (wr_cnt < FULL)) begin
            mem[wr_cnt[AW-1:0]] <= rx_data;
        end
    end

    // Track fill level, published count and read position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            cnt_q  <= '0;
            rd_ptr <= '0;
        end else if (frame_done) begin
            wr_cnt <= '0;
            cnt_q  <= (wr_cnt < FULL) ? wr_cnt + CW'(1) : FULL;
            rd_ptr <= '0;
        end else begin
            if (accept && (wr_cnt < FULL)) begin
                wr_cnt <= wr_cnt + CW'(1);
            end
            if (pop && (cnt_q != '0)) begin
                cnt_q  <= cnt_q - CW'(1);
                rd_ptr <= rd_ptr + CW'(1);
            end
        end
    end
endmodule

// File: rtl/nmb_tx_path.sv
// Transmit path: arms on a byte count, collects that many bytes, then streams
// them out on a valid/ready byte stream with last on the final byte.
// Assumes DEPTH >= 2; counts above DEPTH are clamped.
module nmb_tx_path #(
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic [31:0]   cnt_val,
    input  logic          dat_wr,
    input  logic [7:0]    dat_byte,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    output logic [CW-1:0] count,
    output logic          sent,
    output logic          active
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] fill;
    logic [CW-1:0] len;
    logic [CW-1:0] out_ptr;
    logic          sending;
    logic [CW-1:0] clamp;
    logic          take;

    assign clamp    = (cnt_val > 32'(DEPTH)) ? FULL : cnt_val[CW-1:0];
    assign take     = dat_wr && (cnt_q != '0);
    assign tx_valid = sending;
    assign tx_data  = mem[out_ptr[AW-1:0]];
    assign tx_last  = sending && (out_ptr == len - CW'(1));
    assign sent     = sending && tx_ready && tx_last;
    assign active   = sending || (cnt_q != '0);
    assign count    = cnt_q;

    // Store bytes written by software
    always_ff @(posedge clk) begin
        if (take) begin
            mem[fill[AW-1:0]] <= dat_byte;
        end
    end

    // Arm, collect and stream control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fill    <= '0;
            len     <= '0;
            out_ptr <= '0;
            sending <= 1'b0;
        end else begin
            if (cnt_wr && !active) begin
                cnt_q <= clamp;
                len   <= clamp;
                fill  <= '0;
            end else if (take) begin
                fill <= fill + CW'(1);
                if (fill + CW'(1) == cnt_q) begin
                    cnt_q   <= '0;
                    sending <= 1'b1;
                    out_ptr <= '0;
                end
            end
            if (sending && tx_ready) begin
                if (tx_last) begin
                    sending <= 1'b0;
                end else begin
                    out_ptr <= out_ptr + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/nmb_irq_ctl.sv
// Interrupt status: two write-1-to-clear event bits and a test bit that
// follows writes and clears on read; output is the OR of all three.
// Assumes read and write strobes are never both high.
module nmb_irq_ctl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_done_ev,
    input  logic        rx_done_ev,
    input  logic        wr_en,
    input  logic [2:0]  wr_bits,
    input  logic        rd_en,
    output logic [31:0] status,
    output logic        irq
);
    import nmb_pkg::*;

    logic tx_flag, rx_flag, test_flag;

    assign status = {test_flag, 29'b0, rx_flag, tx_flag};
    assign irq    = tx_flag || rx_flag || test_flag;

    // Event bits: new event wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flag <= 1'b0;
            rx_flag <= 1'b0;
        end else begin
            tx_flag <= (tx_flag && !(wr_en && wr_bits[IRQ_TX])) || tx_done_ev;
            rx_flag <= (rx_flag && !(wr_en && wr_bits[IRQ_RX])) || rx_done_ev;
        end
    end

    // Test bit: follows writes, cleared by reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_flag <= 1'b0;
        end else if (wr_en) begin
            test_flag <= wr_bits[2];
        end else if (rd_en) begin
            test_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/nmb_mailbox.sv
// Top: register decode for the mailbox window, joining receive path,
// transmit path and interrupt control. Reads are combinational in the access
// cycle; side effects of a read take place at the closing clock edge.
module nmb_mailbox #(
    parameter int          DEPTH     = 256,
    parameter logic [31:0] INFO_WORD = 32'h0000_0000,
    parameter int          CW        = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        irq
);
    import nmb_pkg::*;

    logic          rd_acc, wr_acc;
    logic [CW-1:0] rx_cnt, tx_cnt;
    logic [7:0]    rx_byte;
    logic          rx_done, rx_busy, tx_sent, tx_busy;
    logic [31:0]   irq_stat;

    assign rd_acc = bus_sel && !bus_we;
    assign wr_acc = bus_sel && bus_we;

    nmb_rx_path #(.DEPTH(DEPTH), .CW(CW)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_ready(rx_ready),
        .blocked(irq_stat[IRQ_RX]),
        .pop(rd_acc && (bus_addr == OFS_RXDAT)),
        .count(rx_cnt), .head_byte(rx_byte),
        .frame_done(rx_done), .receiving(rx_busy)
    );

    nmb_tx_path #(.DEPTH(DEPTH), .CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .cnt_wr(wr_acc && (bus_addr == OFS_TXCNT)), .cnt_val(bus_wdata),
        .dat_wr(wr_acc && (bus_addr == OFS_TXDAT)), .dat_byte(bus_wdata[7:0]),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready),
        .count(tx_cnt), .sent(tx_sent), .active(tx_busy)
    );

    nmb_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_done_ev(tx_sent), .rx_done_ev(rx_done),
        .wr_en(wr_acc && (bus_addr == OFS_IRQ)),
        .wr_bits({bus_wdata[IRQ_TEST], bus_wdata[IRQ_RX], bus_wdata[IRQ_TX]}),
        .rd_en(rd_acc && (bus_addr == OFS_IRQ)),
        .status(irq_stat), .irq(irq)
    );

    // Read data multiplexer
    always_comb begin
        bus_rdata = 32'h0;
        if (rd_acc) begin
            case (bus_addr)
                OFS_ID_LO: bus_rdata = DEV_ID[31:0];
                OFS_ID_HI: bus_rdata = DEV_ID[63:32];
                OFS_BUSY:  bus_rdata = {31'b0, rx_busy || tx_busy};
                OFS_RXCNT: bus_rdata = 32'(rx_cnt);
                OFS_TXCNT: bus_rdata = 32'(tx_cnt);
                OFS_IRQ:   bus_rdata = irq_stat;
                OFS_INFO:  bus_rdata = INFO_WORD;
                OFS_RXDAT: bus_rdata = {24'b0, rx_byte};
                default:   bus_rdata = 32'h0;
            endcase
        end
    end
endmodule

// File: rtl/nmb_mailbox_chk.sv
// Checker: temporal properties of the mailbox, bound into every instance.
module nmb_mailbox_chk #(
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_we,
    input logic [5:0]    bus_addr,
    input logic          rx_ready,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          tx_ready,
    input logic [31:0]   irq_stat,
    input logic [CW-1:0] rx_cnt
);
    import nmb_pkg::*;

    assert_rx_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == OFS_RXDAT && rx_cnt != '0)
        |=> rx_cnt == $past(rx_cnt) - CW'(1));

    assert_rx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));

    assert_rx_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stat[IRQ_RX] |-> !rx_ready);

    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_txdone_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat[IRQ_TX] && !$past(irq_stat[IRQ_TX]))
        |-> $past(tx_valid && tx_ready && tx_last));

    assert_test_rdclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == OFS_IRQ) |=> !irq_stat[IRQ_TEST]);
endmodule

bind nmb_mailbox nmb_mailbox_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .irq_stat(irq_stat), .rx_cnt(rx_cnt)
);

// File: tb/nmb_mailbox_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module nmb_mailbox_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam logic [31:0] INFO = 32'h0000_00A5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, tx_last, irq;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    int n_checks = 0, n_errors = 0, got_n = 0;
    logic [7:0] got_data [32];
    logic       got_last [32];
    bit         finished = 0;

    nmb_mailbox #(.DEPTH(DEPTH), .INFO_WORD(INFO)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record transmit handshakes; tx_ready only changes just after posedge
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (got_n < 32) begin
                got_data[got_n] = tx_data;
                got_last[got_n] = tx_last;
            end
            got_n = got_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #(CLK_PERIOD/4);
        d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        bus_read(a, v);
        chk(req, v, exp);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic last);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_last = last;
        while (!rx_ready) @(negedge clk);
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic wait_tx(input int n);
        for (int i = 0; i < 200 && got_n < n; i++) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic t_reset();
        rd_chk(6'h08, 32'h0, "R2 busy after reset");
        rd_chk(6'h0C, 32'h0, "R3 rx count after reset");
        rd_chk(6'h10, 32'h0, "R7 tx count after reset");
        rd_chk(6'h14, 32'h0, "R10 irq reg after reset");
        @(negedge clk);
        chk("R10 irq pin after reset", {31'b0, irq}, 32'h0);
        chk("R6 rx_ready after reset", {31'b0, rx_ready}, 32'h1);
        chk("R7 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
    endtask

    task automatic t_regs();
        rd_chk(6'h00, 32'h45545942, "R1 id low");
        rd_chk(6'h04, 32'h3158424D, "R1 id high");
        rd_chk(6'h18, INFO, "R1 info word");
        rd_chk(6'h24, 32'h0, "R1 unused 0x24");
        rd_chk(6'h3C, 32'h0, "R1 unused 0x3C");
        rd_chk(6'h20, 32'h0, "R1 tx data reads zero");
        bus_write(6'h00, 32'hFFFF_FFFF);
        rd_chk(6'h00, 32'h45545942, "R1 id write ignored");
        bus_write(6'h0C, 32'h5);
        rd_chk(6'h0C, 32'h0, "R1 rx count write ignored");
        bus_write(6'h18, 32'h1234);
        rd_chk(6'h18, INFO, "R1 info write ignored");
    endtask

    task automatic t_rx();
        send_byte(8'h11, 1'b0);
        rd_chk(6'h08, 32'h1, "R2 busy mid frame");
        send_byte(8'h22, 1'b0);
        send_byte(8'h33, 1'b1);
        rd_chk(6'h08, 32'h0, "R2 busy after frame");
        rd_chk(6'h0C, 32'h3, "R3 rx count");
        rd_chk(6'h14, 32'h2, "R3 rx flag");
        @(negedge clk);
        chk("R10 irq pin rx", {31'b0, irq}, 32'h1);
        chk("R6 ready low while pending", {31'b0, rx_ready}, 32'h0);
        rx_valid = 1'b1; rx_data = 8'h99; rx_last = 1'b1;
        repeat (3) @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        rd_chk(6'h0C, 32'h3, "R6 blocked frame ignored");
        rd_chk(6'h1C, 32'h11, "R4 byte 0");
        rd_chk(6'h0C, 32'h2, "R4 count after pop");
        rd_chk(6'h1C, 32'h22, "R4 byte 1");
        rd_chk(6'h1C, 32'h33, "R4 byte 2");
        rd_chk(6'h0C, 32'h0, "R4 count drained");
        rd_chk(6'h1C, 32'h0, "R4 empty read");
        rd_chk(6'h0C, 32'h0, "R4 count stays zero");
        @(negedge clk);
        chk("R6 ready low until flag cleared", {31'b0, rx_ready}, 32'h0);
        bus_write(6'h14, 32'h0);
        rd_chk(6'h14, 32'h2, "R8 write zero keeps rx flag");
        bus_write(6'h14, 32'h2);
        rd_chk(6'h14, 32'h0, "R8 rx flag cleared");
        @(negedge clk);
        chk("R10 irq pin low", {31'b0, irq}, 32'h0);
        chk("R6 ready after clear", {31'b0, rx_ready}, 32'h1);
    endtask

    task automatic t_trunc();
        for (int i = 0; i < 11; i++) send_byte(8'hA0 + 8'(i), i == 10);
        rd_chk(6'h0C, DEPTH, "R5 truncated count");
        for (int i = 0; i < DEPTH; i++) rd_chk(6'h1C, 32'hA0 + i, "R5 truncated data");
        rd_chk(6'h0C, 32'h0, "R5 drained");
        bus_write(6'h14, 32'h2);
    endtask

    task automatic t_tx();
        tx_ready = 1'b0;
        got_n = 0;
        bus_write(6'h10, 32'h3);
        rd_chk(6'h10, 32'h3, "R7 tx count armed");
        rd_chk(6'h08, 32'h1, "R2 busy collecting");
        bus_write(6'h20, 32'hFFFF_FF5A);
        bus_write(6'h20, 32'h5B);
        rd_chk(6'h10, 32'h3, "R7 count held while collecting");
        bus_write(6'h20, 32'h5C);
        rd_chk(6'h10, 32'h0, "R7 count cleared after last byte");
        rd_chk(6'h08, 32'h1, "R2 busy sending");
        bus_write(6'h10, 32'h5);
        rd_chk(6'h10, 32'h0, "R11 count write ignored while sending");
        repeat (3) @(negedge clk);
        chk("R7 valid held", {31'b0, tx_valid}, 32'h1);
        chk("R7 data held", {24'b0, tx_data}, 32'h5A);
        chk("R7 nothing taken", got_n, 0);
        @(posedge clk); #1; tx_ready = 1'b1;
        wait_tx(3);
        chk("R7 byte count out", got_n, 3);
        chk("R7 out 0", {24'b0, got_data[0]}, 32'h5A);
        chk("R7 out 1", {24'b0, got_data[1]}, 32'h5B);
        chk("R7 out 2", {24'b0, got_data[2]}, 32'h5C);
        chk("R7 last flags", {29'b0, got_last[2], got_last[1], got_last[0]}, 32'h4);
        rd_chk(6'h14, 32'h1, "R8 tx done flag");
        rd_chk(6'h08, 32'h0, "R2 idle after send");
        @(negedge clk);
        chk("R10 irq pin tx", {31'b0, irq}, 32'h1);
        bus_write(6'h14, 32'h0);
        rd_chk(6'h14, 32'h1, "R8 write zero keeps tx flag");
        bus_write(6'h14, 32'h1);
        rd_chk(6'h14, 32'h0, "R8 tx flag cleared");
    endtask

    task automatic t_tx_clamp();
        got_n = 0;
        bus_write(6'h10, 32'd100);
        rd_chk(6'h10, DEPTH, "R7 count clamped");
        for (int i = 0; i < DEPTH; i++) bus_write(6'h20, 32'hC0 + i);
        wait_tx(DEPTH);
        chk("R7 clamped byte count", got_n, DEPTH);
        chk("R7 clamped final byte", {24'b0, got_data[DEPTH-1]}, 32'hC0 + DEPTH - 1);
        chk("R7 clamped last flag", {31'b0, got_last[DEPTH-1]}, 32'h1);
        chk("R7 no early last", {31'b0, got_last[DEPTH-2]}, 32'h0);
        bus_write(6'h14, 32'h1);
    endtask

    task automatic t_test_irq();
        bus_write(6'h14, 32'h8000_0000);
        @(negedge clk);
        chk("R10 irq pin test bit", {31'b0, irq}, 32'h1);
        bus_write(6'h14, 32'h0);
        @(negedge clk);
        chk("R9 write zero clears test", {31'b0, irq}, 32'h0);
        bus_write(6'h14, 32'h8000_0000);
        rd_chk(6'h14, 32'h8000_0000, "R9 read returns test bit");
        rd_chk(6'h14, 32'h0, "R9 read cleared test bit");
        @(negedge clk);
        chk("R10 irq pin after read clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_rx();
        t_trunc();
        t_tx();
        t_tx_clamp();
        t_test_irq();
        summary();
    end
endmodule